// File: doc/BRIEF.md
# Deferred-Exception Poison Register File

This block is the integer register file of an in-order core that lets the compiler hoist instructions above branches. Each entry holds a data word and a one-bit poison tag. When a hoisted (speculative) instruction would have faulted, the fault is not taken. The result register is tagged as poisoned instead, and the exception waits until it is known that the value is really needed.

There are two combinational read ports and one write port. Every read returns the data together with its poison tag. The pipeline tells the block what kind of consumer is reading in the current cycle: a normal instruction, a speculative instruction, or a check operation. It also tells the block which operands that consumer actually uses. The block then raises a one-cycle exception pulse together with the index of the register that caused it.

When a speculative instruction writes back, the pipeline passes in the poison of that instruction's sources, as it was read earlier. A poisoned source therefore poisons the result. Register 0 is hard-wired to a clean zero.

Top module: `poison_rf`

## Requirements
- R1: After reset every register reads with its poison tag clear, and `excPulse` is low.
- R2: A non-speculative write (`wrSpec`=0) stores `wrData`, and from the next cycle reads return that data with poison clear. `wrFault` has no effect on a non-speculative write.
- R3: A speculative write with `wrFault`=1 stores `wrData` and sets the register's poison tag. No exception is raised for it.
- R4: A speculative write with `wrSrcPoison`=1 sets the poison tag even when `wrFault`=0.
- R5: A write that is not poisoned clears the poison tag of a register that was poisoned before. A write is not poisoned when it is non-speculative, or when it is speculative with `wrFault`=0 and `wrSrcPoison`=0.
- R6: Register 0 always reads as data zero with poison clear, on both ports. Writes to it are discarded, even when they happen in the same cycle as the read.
- R7: When a read address equals the address being written in the same cycle (and is not 0), the port returns the new data and the new poison tag before the clock edge.
- R8: An op with `opValid`=1, `opSpec`=0 and `opCheck`=0 that uses a poisoned operand (`rdUseX`=1 with `rdPoisonX`=1) makes `excPulse` high in the following cycle. In that cycle `excReg` holds the offending register's index. If both used operands are poisoned, port A's index is reported. An operand whose `rdUseX`=0 never causes an exception.
- R9: A speculative op (`opSpec`=1, `opCheck`=0) never raises an exception, whatever the poison of its operands.
- R10: A check op (`opValid`=1, `opCheck`=1) examines port A only. If port A is poisoned, it raises `excPulse` in the next cycle with `excReg` equal to `rdAddrA`. If port A is clean, it raises nothing. This applies whatever the value of `opSpec`.
- R11: `excPulse` is a one-cycle pulse per faulting op. It is low in the cycle that follows any cycle with `opValid`=0, or with an op that does not fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | IDX_W | Destination register index |
| wrData | input | DATA_W | Data to write |
| wrSpec | input | 1 | Writing instruction is speculative |
| wrFault | input | 1 | Writing instruction would have faulted |
| wrSrcPoison | input | 1 | A source of the writing instruction was poisoned |
| rdAddrA | input | IDX_W | Read port A index |
| rdAddrB | input | IDX_W | Read port B index |
| rdDataA | output | DATA_W | Read port A data |
| rdDataB | output | DATA_W | Read port B data |
| rdPoisonA | output | 1 | Read port A poison tag |
| rdPoisonB | output | 1 | Read port B poison tag |
| opValid | input | 1 | A consumer is reading in this cycle |
| opSpec | input | 1 | The consumer is speculative |
| opCheck | input | 1 | The consumer is a check op on port A |
| rdUseA | input | 1 | The consumer uses port A |
| rdUseB | input | 1 | The consumer uses port B |
| excPulse | output | 1 | Deferred exception, one-cycle pulse |
| excReg | output | IDX_W | Index of the offending register |

## Verification
Read data and poison are combinational. They are due in the same cycle as the address, or in the same cycle as a matching write through the bypass. A write becomes visible from storage one edge after it is driven. The exception is registered: `excPulse` and `excReg` are due one rising edge after the op is presented, and they hold for exactly one cycle. The bench drives every input at the falling edge and samples read ports 1 ns later, before the next rising edge. It checks the exception outputs of op k at the falling edge at which op k+1 is driven. This keeps back-to-back ops aligned to that single register stage.

// File: rtl/poison_rf_pkg.sv
package poison_rf_pkg;

  // Strobes passed from the control to the datapath each cycle.
  typedef struct packed {
    logic wrEnable;   // commit the write (address is not register 0)
    logic wrPoison;   // poison value to store with the write
    logic excFire;    // deferred exception must be raised next cycle
    logic excPickB;   // report port B's index instead of port A's
  } rfStrobes_t;

endpackage

// File: rtl/poison_rf_ctrl.sv
module poison_rf_ctrl
  import poison_rf_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrAddr,
  input  logic             wrSpec,
  input  logic             wrFault,
  input  logic             wrSrcPoison,
  input  logic             opValid,
  input  logic             opSpec,
  input  logic             opCheck,
  input  logic             rdUseA,
  input  logic             rdUseB,
  input  logic             rdPoisonA,
  input  logic             rdPoisonB,
  output rfStrobes_t       strobes
);

  logic hitA;
  logic hitB;

  always_comb begin
    // Port A faults for a check op, or for a normal consumer that uses it.
    hitA = rdPoisonA && (opCheck || (!opSpec && rdUseA));
    // Port B faults only for a normal, non-check consumer that uses it.
    hitB = rdPoisonB && !opSpec && !opCheck && rdUseB;

    strobes.wrEnable = wrEn && (wrAddr != '0);
    strobes.wrPoison = wrSpec && (wrFault || wrSrcPoison);
    strobes.excFire  = opValid && (hitA || hitB);
    strobes.excPickB = !hitA;
  end

endmodule

// File: rtl/poison_rf_datapath.sv
module poison_rf_datapath
  import poison_rf_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 128,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rfStrobes_t        strobes,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdAddr [2],
  output logic [DATA_W-1:0] rdData [2],
  output logic              rdPoison [2],
  output logic              excPulse,
  output logic [IDX_W-1:0]  excReg
);

  logic [DATA_W-1:0]   dataMem [NUM_REGS];
  logic [NUM_REGS-1:0] poisonVec;

  // Data storage carries no reset; only the poison tags are cleared.
  always_ff @(posedge clk) begin
    if (strobes.wrEnable) dataMem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) poisonVec <= '0;
    else if (strobes.wrEnable) poisonVec[wrAddr] <= strobes.wrPoison;
  end

  // Read ports: register 0 is a clean zero, then the write-first bypass, then storage.
  for (genvar p = 0; p < 2; p++) begin : g_rdPort
    always_comb begin
      if (rdAddr[p] == '0) begin
        rdData[p]   = '0;
        rdPoison[p] = 1'b0;
      end else if (strobes.wrEnable && (wrAddr == rdAddr[p])) begin
        rdData[p]   = wrData;
        rdPoison[p] = strobes.wrPoison;
      end else begin
        rdData[p]   = dataMem[rdAddr[p]];
        rdPoison[p] = poisonVec[rdAddr[p]];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      excPulse <= 1'b0;
      excReg   <= '0;
    end else begin
      excPulse <= strobes.excFire;
      if (strobes.excFire) excReg <= strobes.excPickB ? rdAddr[1] : rdAddr[0];
    end
  end

endmodule

// File: rtl/poison_rf.sv
module poison_rf
  import poison_rf_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 128,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrSpec,
  input  logic              wrFault,
  input  logic              wrSrcPoison,
  input  logic [IDX_W-1:0]  rdAddrA,
  input  logic [IDX_W-1:0]  rdAddrB,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic              rdPoisonA,
  output logic              rdPoisonB,
  input  logic              opValid,
  input  logic              opSpec,
  input  logic              opCheck,
  input  logic              rdUseA,
  input  logic              rdUseB,
  output logic              excPulse,
  output logic [IDX_W-1:0]  excReg
);

  rfStrobes_t        strobes;
  logic [IDX_W-1:0]  rdAddrArr [2];
  logic [DATA_W-1:0] rdDataArr [2];
  logic              rdPoisonArr [2];

  assign rdAddrArr[0] = rdAddrA;
  assign rdAddrArr[1] = rdAddrB;
  assign rdDataA      = rdDataArr[0];
  assign rdDataB      = rdDataArr[1];
  assign rdPoisonA    = rdPoisonArr[0];
  assign rdPoisonB    = rdPoisonArr[1];

  poison_rf_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrSpec      (wrSpec),
    .wrFault     (wrFault),
    .wrSrcPoison (wrSrcPoison),
    .opValid     (opValid),
    .opSpec      (opSpec),
    .opCheck     (opCheck),
    .rdUseA      (rdUseA),
    .rdUseB      (rdUseB),
    .rdPoisonA   (rdPoisonArr[0]),
    .rdPoisonB   (rdPoisonArr[1]),
    .strobes     (strobes)
  );

  poison_rf_datapath #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .IDX_W    (IDX_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .rdAddr   (rdAddrArr),
    .rdData   (rdDataArr),
    .rdPoison (rdPoisonArr),
    .excPulse (excPulse),
    .excReg   (excReg)
  );

endmodule

// File: rtl/poison_rf_checker.sv
module poison_rf_checker #(
  parameter int DATA_W   = 64,
  parameter int NUM_REGS = 128,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [IDX_W-1:0]  wrAddr,
  input logic              wrSpec,
  input logic              wrFault,
  input logic [IDX_W-1:0]  rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic              rdPoisonA,
  input logic              opValid,
  input logic              opSpec,
  input logic              opCheck,
  input logic              rdUseA,
  input logic              excPulse,
  input logic [IDX_W-1:0]  excReg
);

  assert_reg0_clean_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == '0) |-> (rdDataA == '0) && !rdPoisonA);

  assert_spec_fault_poisons_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSpec && wrFault && (wrAddr != '0))
    |=> (rdAddrA != $past(wrAddr)) || rdPoisonA || (wrEn && (wrAddr == rdAddrA)));

  assert_nonspec_use_raises_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !opSpec && !opCheck && rdUseA && rdPoisonA)
    |=> excPulse && (excReg == $past(rdAddrA)));

  assert_spec_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opSpec && !opCheck) |=> !excPulse);

  assert_check_raises_R10: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCheck && rdPoisonA) |=> excPulse && (excReg == $past(rdAddrA)));

  assert_idle_no_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> !excPulse);

endmodule

bind poison_rf poison_rf_checker #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_checker (.*);

// File: tb/poison_rf_bench.sv
`timescale 1ns/1ps
module poison_rf_bench;

  localparam int DW = 16;
  localparam int NR = 16;
  localparam int IW = $clog2(NR);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0, wrSpec = 1'b0, wrFault = 1'b0, wrSrcPoison = 1'b0;
  logic [IW-1:0] wrAddr = '0, rdAddrA = '0, rdAddrB = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdDataA, rdDataB;
  logic          rdPoisonA, rdPoisonB;
  logic          opValid = 1'b0, opSpec = 1'b0, opCheck = 1'b0, rdUseA = 1'b0, rdUseB = 1'b0;
  logic          excPulse;
  logic [IW-1:0] excReg;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 0;

  logic [DW-1:0] modelData [NR];
  logic          modelPois [NR];

  always #2 clk = ~clk;

  poison_rf #(.DATA_W(DW), .NUM_REGS(NR)) u_poison_rf (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrSpec(wrSpec), .wrFault(wrFault), .wrSrcPoison(wrSrcPoison),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .rdDataA(rdDataA), .rdDataB(rdDataB),
    .rdPoisonA(rdPoisonA), .rdPoisonB(rdPoisonB), .opValid(opValid), .opSpec(opSpec),
    .opCheck(opCheck), .rdUseA(rdUseA), .rdUseB(rdUseB),
    .excPulse(excPulse), .excReg(excReg)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expData(int i);
    return (i == 0) ? '0 : modelData[i];
  endfunction

  function automatic logic expPois(int i);
    return (i == 0) ? 1'b0 : modelPois[i];
  endfunction

  // Sweep both ports over all registers; port B walks in reverse.
  task automatic sweepRead(string tag, bit withData);
    for (int i = 0; i < NR; i++) begin
      @(negedge clk);
      rdAddrA = IW'(i);
      rdAddrB = IW'(NR - 1 - i);
      #1;
      check(rdPoisonA == expPois(i), tag, rdPoisonA, expPois(i));
      check(rdPoisonB == expPois(NR - 1 - i), tag, rdPoisonB, expPois(NR - 1 - i));
      if (withData) begin
        check(rdDataA == expData(i), tag, rdDataA, expData(i));
        check(rdDataB == expData(NR - 1 - i), tag, rdDataB, expData(NR - 1 - i));
      end
    end
  endtask

  task automatic doWrite(int a, logic [DW-1:0] d, bit spec, bit fault, bit src);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = IW'(a); wrData = d;
    wrSpec = spec; wrFault = fault; wrSrcPoison = src;
    @(negedge clk);
    wrEn = 1'b0;
    if (a != 0) begin
      modelData[a] = d;
      modelPois[a] = spec && (fault || src);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit expFire, prevFire;
    int expIdx, prevIdx;
    string prevTag;

    for (int i = 0; i < NR; i++) begin
      modelData[i] = '0;
      modelPois[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    @(negedge clk);
    check(excPulse == 1'b0, "R1 excPulse", excPulse, 0);
    sweepRead("R1 poison after reset", 1'b0);

    // R2 and R6: plain writes; register 0 write attempt; wrFault ignored on non-speculative writes
    for (int i = 0; i < NR; i++)
      doWrite(i, DW'(i * 16'h0101 ^ 16'h5a5a), 1'b0, (i % 3) == 0, 1'b0);
    sweepRead("R2 R6 plain write", 1'b1);

    // R3, R4, R5: poisoning and clean rewrites
    for (int i = 1; i < NR; i++) begin
      if (i % 2 == 1)      doWrite(i, DW'(i * 3 + 16'h1000), 1'b1, 1'b1, 1'b0);
      else if (i % 4 == 2) doWrite(i, DW'(i * 5 + 16'h2000), 1'b1, 1'b0, 1'b1);
      else                 doWrite(i, DW'(i * 7 + 16'h3000), 1'b0, 1'b1, 1'b1);
    end
    doWrite(8, 16'h0808, 1'b1, 1'b0, 1'b0);
    doWrite(3, 16'h0303, 1'b0, 1'b0, 1'b0);
    doWrite(5, 16'h0505, 1'b1, 1'b0, 1'b0);
    sweepRead("R3 R4 R5 poison set and clear", 1'b1);

    // R7: write-first bypass on both ports
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 4'd6; wrData = 16'hbeef; wrSpec = 1'b1; wrFault = 1'b1; wrSrcPoison = 1'b0;
    rdAddrA = 4'd6; rdAddrB = 4'd6;
    #1;
    check(rdDataA == 16'hbeef, "R7 bypass data A", rdDataA, 16'hbeef);
    check(rdPoisonA == 1'b1, "R7 bypass poison A", rdPoisonA, 1);
    check(rdDataB == 16'hbeef, "R7 bypass data B", rdDataB, 16'hbeef);
    @(negedge clk);
    modelData[6] = 16'hbeef; modelPois[6] = 1'b1;
    wrAddr = 4'd4; wrData = 16'hc0de; wrSpec = 1'b0; wrFault = 1'b0;
    #1;
    check(rdPoisonA == 1'b1, "R7 stored after bypass", rdPoisonA, 1);
    check(rdDataA == 16'hbeef, "R7 stored data", rdDataA, 16'hbeef);
    rdAddrB = 4'd4;
    #1;
    check(rdPoisonB == 1'b0, "R7 clean bypass B", rdPoisonB, 0);
    check(rdDataB == 16'hc0de, "R7 clean bypass data B", rdDataB, 16'hc0de);
    @(negedge clk);
    modelData[4] = 16'hc0de; modelPois[4] = 1'b0;
    wrAddr = 4'd0; wrData = 16'hffff; wrSpec = 1'b1; wrFault = 1'b1;
    rdAddrA = 4'd0;
    #1;
    check(rdDataA == '0, "R6 bypass to reg0 data", rdDataA, 0);
    check(rdPoisonA == 1'b0, "R6 bypass to reg0 poison", rdPoisonA, 0);
    @(negedge clk);
    wrEn = 1'b0;

    // R8..R11: every operand pair under every consumer kind, back to back
    prevFire = 1'b0; prevIdx = 0; prevTag = "R11";
    for (int a = 0; a < NR; a++) begin
      for (int b = 0; b < NR; b++) begin
        for (int m = 0; m < 16; m++) begin
          bit uA, uB, sp, ck, hA, hB;
          @(negedge clk);
          check(excPulse == prevFire, prevTag, excPulse, prevFire);
          if (prevFire) check(excReg == IW'(prevIdx), prevTag, excReg, prevIdx);
          uA = m[0]; uB = m[1]; sp = m[2]; ck = m[3];
          opValid = 1'b1; rdAddrA = IW'(a); rdAddrB = IW'(b);
          rdUseA = uA; rdUseB = uB; opSpec = sp; opCheck = ck;
          hA = expPois(a) && (ck || (!sp && uA));
          hB = expPois(b) && !sp && !ck && uB;
          expFire = hA || hB;
          expIdx = hA ? a : b;
          prevFire = expFire; prevIdx = expIdx;
          prevTag = ck ? "R10 check op" : (sp ? "R9 speculative consumer" : "R8 normal consumer");
        end
        @(negedge clk);
        check(excPulse == prevFire, prevTag, excPulse, prevFire);
        if (prevFire) check(excReg == IW'(prevIdx), prevTag, excReg, prevIdx);
        opValid = 1'b0;
        prevFire = 1'b0; prevTag = "R11 idle after op";
      end
    end
    @(negedge clk);
    check(excPulse == 1'b0, prevTag, excPulse, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule